// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Window

This block holds a 256-entry colour lookup table. Each entry stores an 8-bit red, an 8-bit green and an 8-bit blue value. A host programs the table through a small write window of four word registers. It first writes an entry number to the index register. It then writes the data register three times, once for each component. A scanout pipeline presents an 8-bit pixel value on a separate lookup port. One cycle later it receives that entry's packed colour.

The component sequencer always starts on red. Writing the index register restarts the sequence. The entry number stays where it is after blue, so a second triplet lands on the same entry. Reads of the window carry no information and always return zero.

Top module: `clut_top`

## Requirements
- R1: The register is chosen by address bits [3:2] (0 = index register, 1 = data register). Address bits [1:0] have no effect on which register is written.
- R2: A write to the index register loads the entry number from data bits [31:24] and returns the component sequence to red.
- R3: Successive writes to the data register store data bits [31:24] into red, then green, then blue of the selected entry. After blue, the sequence returns to red.
- R4: The entry number does not advance after the blue write. A further triplet overwrites the same entry, and the next entry stays unchanged.
- R5: Writes to registers 2 and 3 change neither the table, the entry number nor the sequence position.
- R6: The host read data is zero for every address, whether or not a read is requested.
- R7: After reset, entries 0 to 254 read as 0x000000 and entry 255 reads as 0xFFFFFF. The entry number and sequence position are zero, so the first data write after reset goes to the red component of entry 0.
- R8: The lookup port is registered. The entry number sampled at a clock edge appears on the colour output after that edge, packed as red [23:16], green [15:8], blue [7:0]. The output holds its old value until that edge.
- R9: A component write that is sampled at an edge is visible on the lookup port from the following edge on. A lookup of the same entry at the write edge returns the prior value.
- R10: Data bits [23:0] have no effect on any stored value or on the entry number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 4 | Host byte address within the register window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, always zero |
| lk_idx | input | 8 | Pixel value to look up |
| lk_rgb | output | 24 | Registered colour of the looked-up entry |

## Verification
A host component write and a scanout lookup of the very same entry can fall on one clock edge. The bench provokes this by driving the blue write and the lookup index for that entry in the same cycle. It judges the result by requiring the old colour after that edge and the new colour one edge later. A second overlap, a restarting index write in the middle of a triplet, is judged by where the next data byte lands.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int unsigned CW      = 8;
  localparam int unsigned NCOMP   = 3;
  localparam int unsigned ENTRIES = 256;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    REG_INDEX = 2'd0,
    REG_DATA  = 2'd1,
    REG_SPARE2 = 2'd2,
    REG_SPARE3 = 2'd3
  } reg_e;

  // word register number inside the 16-byte window
  function automatic reg_e word_of(input logic [3:0] byte_addr);
    return reg_e'(byte_addr[3:2]);
  endfunction

  // payload byte carried in the top lane of a 32-bit write
  function automatic logic [CW-1:0] top_byte(input logic [31:0] w);
    return w[31:32-CW];
  endfunction

  // reset contents: the last entry is full scale, all others zero
  function automatic logic [CW-1:0] reset_level(input int unsigned entry);
    return (entry == ENTRIES-1) ? {CW{1'b1}} : {CW{1'b0}};
  endfunction

  // next sequencer position after a data write; illegal codes behave as red
  function automatic comp_e next_comp(input comp_e cur);
    case (cur)
      COMP_G:  return COMP_B;
      COMP_B:  return COMP_R;
      default: return COMP_G;
    endcase
  endfunction

  // one-hot component write enable (bit0 red, bit1 green, bit2 blue)
  function automatic logic [NCOMP-1:0] comp_onehot(input comp_e cur);
    case (cur)
      COMP_G:  return 3'b010;
      COMP_B:  return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/clut_decode.sv
module clut_decode
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              idx_load,
  output logic              data_push,
  output logic              spare_wr
);

  reg_e sel;

  always_comb begin
    sel       = word_of(host_addr[3:0]);
    idx_load  = host_we && (sel == REG_INDEX);
    data_push = host_we && (sel == REG_DATA);
    spare_wr  = host_we && ((sel == REG_SPARE2) || (sel == REG_SPARE3));
  end

endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic             data_push,
  input  logic [CW-1:0]    wr_byte,
  output logic [IDX_W-1:0] cur_idx,
  output comp_e            seq_state,
  output logic [NCOMP-1:0] comp_we
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx   <= '0;
      seq_state <= COMP_R;
    end else if (idx_load) begin
      cur_idx   <= wr_byte;
      seq_state <= COMP_R;
    end else if (data_push) begin
      seq_state <= next_comp(seq_state);
    end
  end

  always_comb begin
    comp_we = data_push ? comp_onehot(seq_state) : '0;
  end

endmodule

// File: rtl/clut_bank.sv
module clut_bank
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [CW-1:0]    rdata
);

  logic [CW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        mem[i] <= reset_level(i);
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/clut_top.sv
module clut_top
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic                  host_re,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [31:0]           host_wdata,
  output logic [31:0]           host_rdata,
  input  logic [IDX_W-1:0]      lk_idx,
  output logic [NCOMP*CW-1:0]   lk_rgb
);

  // named internal events, observed by the bound checker
  logic             idx_load;
  logic             data_push;
  logic             spare_wr;
  logic [IDX_W-1:0] cur_idx;
  comp_e            seq_state;
  logic [NCOMP-1:0] comp_we;
  logic [CW-1:0]    wr_byte;
  logic [CW-1:0]    rd_comp [NCOMP];

  // reads carry no data; low data lanes and spare writes are dropped
  wire unused_inputs = ^{host_re, host_wdata[31-CW:0], spare_wr};

  assign host_rdata = '0;
  assign wr_byte    = top_byte(host_wdata);

  clut_decode #(.ADDR_W(ADDR_W)) u_dec (
    .host_we   (host_we),
    .host_addr (host_addr),
    .idx_load  (idx_load),
    .data_push (data_push),
    .spare_wr  (spare_wr)
  );

  clut_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_load  (idx_load),
    .data_push (data_push),
    .wr_byte   (wr_byte),
    .cur_idx   (cur_idx),
    .seq_state (seq_state),
    .comp_we   (comp_we)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    clut_bank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (comp_we[c]),
      .waddr (cur_idx),
      .wdata (wr_byte),
      .raddr (lk_idx),
      .rdata (rd_comp[c])
    );
    // component 0 (red) occupies the most significant byte
    assign lk_rgb[(NCOMP-1-c)*CW +: CW] = rd_comp[c];
  end

endmodule

// File: rtl/clut_chk.sv
module clut_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       host_wdata,
  input logic              idx_load,
  input logic [2:0]        comp_we,
  input logic [7:0]        cur_idx,
  input logic [1:0]        seq_state
);

  // R3
  comp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

  // R1
  idx_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr[3:2] == 2'd0) |-> idx_load && comp_we == 3'b000);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (cur_idx == $past(host_wdata[31:24])) && (seq_state == 2'd0));

  // R3
  red_then_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_we[0] |=> seq_state == 2'd1);

  // R3
  blue_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_we[2] |=> seq_state == 2'd0);

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_we != 3'b000) |=> $stable(cur_idx));

  // R5
  spare_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr[3]) |=> $stable(cur_idx) && $stable(seq_state));

  // R5
  spare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr[3]) |-> comp_we == 3'b000);

endmodule

bind clut_top clut_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .idx_load   (idx_load),
  .comp_we    (comp_we),
  .cur_idx    (cur_idx),
  .seq_state  (seq_state)
);

// File: tb/clut_top_tb.sv
`timescale 1ns/1ps
module clut_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic        host_re;
  logic [3:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [7:0]  lk_idx;
  logic [23:0] lk_rgb;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model of the table and write sequencer
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_pos;

  always #2 clk = ~clk;

  clut_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .lk_idx     (lk_idx),
    .lk_rgb     (lk_rgb)
  );

  function automatic logic [23:0] model_rgb(input logic [7:0] i);
    return {m_r[i], m_g[i], m_b[i]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_r[i] = (i == 255) ? 8'hFF : 8'h00;
      m_g[i] = (i == 255) ? 8'hFF : 8'h00;
      m_b[i] = (i == 255) ? 8'hFF : 8'h00;
    end
    m_idx = 8'h00;
    m_pos = 0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    case (a[3:2])
      2'd0: begin m_idx = d[31:24]; m_pos = 0; end
      2'd1: begin
        case (m_pos)
          0: m_r[m_idx] = d[31:24];
          1: m_g[m_idx] = d[31:24];
          default: m_b[m_idx] = d[31:24];
        endcase
        m_pos = (m_pos + 1) % 3;
      end
      default: ;
    endcase
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_wdata = 32'h0;
    model_write(a, d);
  endtask

  task automatic look(input logic [7:0] i, input string req);
    @(negedge clk);
    lk_idx = i;
    @(negedge clk);
    check(req, {8'h0, lk_rgb}, {8'h0, model_rgb(i)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic t_reset_state();
    do_reset();
    look(8'd0,   "R7 entry0");
    look(8'd77,  "R7 entry77");
    look(8'd254, "R7 entry254");
    look(8'd255, "R7 entry255 white");
    check("R6 rdata idle", host_rdata, 32'h0);
    // first data write after reset lands on red of entry 0
    bus_write(4'h4, 32'hAB00_0000);
    look(8'd0, "R7 first write red of entry0");
    check("R7 entry0 value", {8'h0, lk_rgb}, 32'h00AB_0000);
  endtask

  task automatic t_triplet();
    bus_write(4'h0, 32'h05FF_FFFF);
    bus_write(4'h4, 32'h12_345678);
    bus_write(4'h4, 32'h34_ABCDEF);
    bus_write(4'h4, 32'h56_000001);
    look(8'd5, "R3 triplet");
    check("R10 low bits dropped", {8'h0, lk_rgb}, 32'h0012_3456);
    look(8'd6, "R10 neighbour intact");
  endtask

  task automatic t_restart();
    bus_write(4'h0, 32'h0900_0000);
    bus_write(4'h4, 32'hAA00_0000);
    bus_write(4'h4, 32'hBB00_0000);
    bus_write(4'h0, 32'h0900_0000);
    bus_write(4'h4, 32'hCC00_0000);
    look(8'd9, "R2 restart to red");
    check("R2 red overwritten", {8'h0, lk_rgb}, 32'h00CC_BB00);
  endtask

  task automatic t_no_advance();
    bus_write(4'h0, 32'h2000_0000);
    for (int k = 0; k < 6; k++) bus_write(4'h4, {8'(8'h10 + k), 24'h0});
    look(8'd32, "R4 second triplet same entry");
    check("R4 value", {8'h0, lk_rgb}, 32'h0013_1415);
    look(8'd33, "R4 next entry untouched");
  endtask

  task automatic t_spare_and_lanes();
    bus_write(4'h0, 32'h4000_0000);
    bus_write(4'h4, 32'h7100_0000);
    bus_write(4'h8, 32'h4100_0000);
    bus_write(4'hC, 32'h4200_0000);
    bus_write(4'h7, 32'h7200_0000);
    bus_write(4'h5, 32'h7300_0000);
    look(8'd64, "R5 spare writes ignored");
    check("R1 R5 value", {8'h0, lk_rgb}, 32'h0071_7273);
    look(8'd65, "R5 entry65 untouched");
    look(8'd66, "R5 entry66 untouched");
    bus_write(4'h3, 32'h5000_0000);
    bus_write(4'h6, 32'h9900_0000);
    look(8'd80, "R1 byte offset index");
  endtask

  task automatic t_reads();
    for (int a = 0; a < 16; a += 5) begin
      @(negedge clk);
      host_re = 1'b1; host_addr = 4'(a);
      #1 check("R6 read zero", host_rdata, 32'h0);
    end
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic t_same_cycle();
    bus_write(4'h0, 32'h1400_0000);
    bus_write(4'h4, 32'h1100_0000);
    bus_write(4'h4, 32'h2200_0000);
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'h4; host_wdata = 32'h3300_0000; lk_idx = 8'd20;
    @(negedge clk);
    host_we = 1'b0;
    check("R9 same edge old value", {8'h0, lk_rgb}, 32'h0011_2200);
    @(negedge clk);
    check("R9 next edge new value", {8'h0, lk_rgb}, 32'h0011_2233);
    model_write(4'h4, 32'h3300_0000);
  endtask

  task automatic t_latency();
    look(8'd255, "R8 white");
    @(negedge clk);
    lk_idx = 8'd0;
    #1 check("R8 holds before edge", {8'h0, lk_rgb}, 32'h00FF_FFFF);
    @(negedge clk);
    check("R8 after edge", {8'h0, lk_rgb}, {8'h0, model_rgb(8'd0)});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_re = 1'b0;
    host_addr = 4'h0; host_wdata = 32'h0; lk_idx = 8'h0;
    model_reset();
    t_reset_state();
    t_triplet();
    t_restart();
    t_no_advance();
    t_spare_and_lanes();
    t_reads();
    t_same_cycle();
    t_latency();
    finish_run();
  end

endmodule